// File: doc/BRIEF.md
# Conditional Branch Program Counter

This block keeps the fetch address of a small 16-bit processor. On every clock edge where the step enable is high, it looks at the instruction word currently presented. If the word is a conditional branch and the comparison flag that branch asks for is set, the block loads the branch target into the program counter. Otherwise the counter moves on to the next instruction. A registered strobe marks each cycle in which a branch target has just been loaded.

The comparison flags come from an earlier compare operation elsewhere in the core. They arrive as three one-hot bits: equal, greater and less. Instruction memory, the register file and the ALU sit outside this block. Every pin here is a plain control or status signal sampled on each edge. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The step enable is the only way to stall the counter.

Top module: `branch_pc_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets pc to 0x0000 and branch_taken to 0.
- R2: With step_en low, pc keeps its value and branch_taken is 0 on the next cycle, whatever the instruction and flags are.
- R3: With step_en high and instr[1:0] not equal to 2'b10, pc becomes pc+1 and branch_taken is 0.
- R4: A branch word (instr[1:0]=2'b10) with condition code instr[3:2]=2'b00 is taken when flags[0] (equal) is 1.
- R5: A branch word with condition code 2'b01 is taken when flags[1] (greater) is 1.
- R6: A branch word with condition code 2'b10 is taken when flags[2] (less) is 1.
- R7: A branch word whose selected flag is 0 is not taken: pc becomes pc+1 and branch_taken is 0.
- R8: A branch word with condition code 2'b11 is never taken, even with all three flags set.
- R9: A taken branch loads pc with instr[15:4] zero-extended, so pc[15:12] is 0.
- R10: Stepping from pc 0xFFFF gives 0x0000.
- R11: branch_taken is 1 for exactly the cycle after the edge that loads a target, and it falls again unless the next edge also takes a branch.
- R12: Flags that the condition code does not select have no effect on whether the branch is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Allows pc to advance or branch on this edge |
| instr | input | 16 | Instruction word at the current pc |
| flags | input | 3 | Compare flags: bit 0 equal, bit 1 greater, bit 2 less |
| pc | output | 16 | Current program counter |
| branch_taken | output | 1 | High for one cycle after a target has been loaded |

## Verification
Both outputs are registered. The pc and branch_taken values caused by a set of inputs appear one cycle after those inputs are applied: they are sampled on the next rising edge and become visible just after it. The driver changes the inputs on the falling edge and pushes the expected pc and strobe into a queue. The monitor pops one entry 2 ns after every rising edge that follows a drive, so each comparison lands in the single cycle where that result is valid. The wrap check walks the counter all the way up to 0xFFFF, so the same one-cycle timing is checked across many consecutive steps.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic [1:0] {
    COND_EQ   = 2'd0,
    COND_GT   = 2'd1,
    COND_LT   = 2'd2,
    COND_NONE = 2'd3
  } cond_e;

  localparam logic [1:0] FMT_BRANCH = 2'b10;
  localparam int         NUM_FLAGS  = 3;

endpackage

// File: rtl/bpc_decode.sv
module bpc_decode
  import bpc_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int PC_W    = 16,
  parameter int TGT_LSB = 4,
  parameter int TGT_W   = 12
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               is_branch,
  output cond_e              cond,
  output logic [PC_W-1:0]    target
);

  localparam int TGT_MSB = TGT_LSB + TGT_W - 1;
  localparam int PAD_W   = PC_W - TGT_W;

  always_comb begin
    is_branch = (instr[1:0] == FMT_BRANCH);
    cond      = cond_e'(instr[3:2]);
    target    = {{PAD_W{1'b0}}, instr[TGT_MSB:TGT_LSB]};
  end

endmodule

// File: rtl/bpc_cond_eval.sv
module bpc_cond_eval
  import bpc_pkg::*;
(
  input  logic                 is_branch,
  input  cond_e                cond,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 take
);

  logic [NUM_FLAGS-1:0] hit;

  // Each code value picks the flag with the same index; the unused code has no flag
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hit
    assign hit[i] = (cond == cond_e'(i)) && flags[i];
  end

  assign take = is_branch && (|hit);

endmodule

// File: rtl/bpc_pc_reg.sv
module bpc_pc_reg #(
  parameter int PC_W    = 16,
  parameter int PC_STEP = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc,
  output logic            taken
);

  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      taken <= 1'b0;
    end else if (step_en) begin
      pc    <= take ? target : pc + STEP;
      taken <= take;
    end else begin
      taken <= 1'b0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) $past(rst) |-> (pc == '0 && !taken));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(pc) && !taken));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !take) |=> (pc == $past(pc) + STEP && !taken));

  // R11
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && take) |=> (pc == $past(target) && taken));

endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import bpc_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int PC_W    = 16,
  parameter int TGT_LSB = 4,
  parameter int TGT_W   = 12,
  parameter int PC_STEP = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_en,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [PC_W-1:0]      pc,
  output logic                 branch_taken
);

  logic            is_branch;
  cond_e           cond;
  logic [PC_W-1:0] target;
  logic            take;

  bpc_decode #(
    .INSTR_W(INSTR_W), .PC_W(PC_W), .TGT_LSB(TGT_LSB), .TGT_W(TGT_W)
  ) u_decode (
    .instr    (instr),
    .is_branch(is_branch),
    .cond     (cond),
    .target   (target)
  );

  bpc_cond_eval u_eval (
    .is_branch(is_branch),
    .cond     (cond),
    .flags    (flags),
    .take     (take)
  );

  bpc_pc_reg #(
    .PC_W(PC_W), .PC_STEP(PC_STEP)
  ) u_pc (
    .clk    (clk),
    .rst    (rst),
    .step_en(step_en),
    .take   (take),
    .target (target),
    .pc     (pc),
    .taken  (branch_taken)
  );

  // R8
  never_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && instr[1:0] == 2'b10 && instr[3:2] == 2'b11) |=> !branch_taken);

  // R9
  zext_chk: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> (pc[PC_W-1:TGT_W] == '0));

  // R4
  eq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && instr[1:0] == 2'b10 && instr[3:2] == 2'b00 && flags[0]) |=> branch_taken);

endmodule

// File: tb/test_branch_pc_unit.sv
module test_branch_pc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [2:0]  flags = 3'b000;
  logic [15:0] pc;
  logic        branch_taken;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] q_pc[$];
  bit          q_tk[$];
  string       q_tag[$];
  logic [15:0] mpc = 16'h0000;

  always #5 clk = ~clk;

  branch_pc_unit i_branch_pc_unit (
    .clk(clk), .rst(rst), .step_en(step_en), .instr(instr),
    .flags(flags), .pc(pc), .branch_taken(branch_taken)
  );

  function automatic logic [15:0] br(input logic [11:0] tgt, input logic [1:0] code);
    return {tgt, code, 2'b10};
  endfunction

  task automatic drive(input bit r, input bit en, input logic [15:0] ins,
                       input logic [2:0] fl, input string tag);
    bit tk;
    @(negedge clk);
    rst = r; step_en = en; instr = ins; flags = fl;
    tk = 1'b0;
    if (r) mpc = 16'h0000;
    else if (en) begin
      if (ins[1:0] == 2'b10 &&
          ((ins[3:2] == 2'd0 && fl[0]) || (ins[3:2] == 2'd1 && fl[1]) ||
           (ins[3:2] == 2'd2 && fl[2]))) begin
        tk = 1'b1;
        mpc = {4'h0, ins[15:4]};
      end else mpc = mpc + 16'd1;
    end
    q_pc.push_back(mpc);
    q_tk.push_back(tk);
    q_tag.push_back(tag);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q_pc.size() > 0) begin
      logic [15:0] epc;
      bit etk;
      string tg;
      epc = q_pc.pop_front();
      etk = q_tk.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (pc !== epc || branch_taken !== etk) begin
        failures++;
        $display("FAIL %s: pc=%h taken=%b expected pc=%h taken=%b", tg, pc, branch_taken, epc, etk);
      end
    end
  end

  initial begin
    drive(1, 0, 16'h0000, 3'b000, "R1 reset");
    drive(0, 1, 16'h1234, 3'b111, "R3 non-branch step");
    drive(0, 1, 16'hFFFF, 3'b000, "R3 format 11 step");
    drive(0, 1, 16'h0001, 3'b111, "R3 format 01 step");
    drive(0, 0, br(12'h0AB, 2'd0), 3'b001, "R2 hold with branch");
    drive(0, 0, 16'h0000, 3'b000, "R2 hold idle");
    drive(0, 1, br(12'h123, 2'd0), 3'b001, "R4 eq taken");
    drive(0, 1, 16'h0000, 3'b000, "R11 strobe falls");
    drive(0, 1, br(12'h456, 2'd1), 3'b010, "R5 gt taken");
    drive(0, 1, br(12'h789, 2'd2), 3'b100, "R6 lt taken back-to-back R11");
    drive(0, 1, br(12'h321, 2'd0), 3'b110, "R7 eq not set");
    drive(0, 1, br(12'h321, 2'd1), 3'b101, "R7 gt not set");
    drive(0, 1, br(12'h321, 2'd2), 3'b011, "R7 lt not set");
    drive(0, 1, br(12'hABC, 2'd3), 3'b111, "R8 code 11 never");
    drive(0, 1, br(12'h0F0, 2'd1), 3'b110, "R12 extra flag ignored");
    drive(0, 1, br(12'hFFF, 2'd2), 3'b111, "R9 max target zero-extended");
    drive(0, 1, br(12'h010, 2'd0), 3'b000, "R12 no flag");
    drive(1, 1, br(12'h555, 2'd0), 3'b001, "R1 reset over branch");
    drive(0, 1, br(12'hFFF, 2'd0), 3'b001, "R9 load 0FFF");
    while (mpc != 16'hFFFF) drive(0, 1, 16'h0000, 3'b000, "R3 long step");
    drive(0, 1, 16'h0000, 3'b000, "R10 wrap to zero");
    drive(0, 1, 16'h0000, 3'b000, "R3 after wrap");
    drive(0, 0, 16'h0000, 3'b000, "R2 final hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule